// File: doc/BRIEF.md
# Four-State Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a direct-mapped table of small 2-bit state machines. The table is indexed by the word address of the branch, reduced modulo the number of slots. A fetch-side lookup port turns a program counter into a taken or not-taken guess. The guess comes from the upper bit of the slot's state, and the lookup is purely combinational.

A resolve-side update port takes the program counter of a branch whose outcome is now known, together with that outcome. On the next clock edge it moves the matching slot along a fixed four-state transition table. This table is not a saturating counter. From the weak not-taken state, a taken outcome jumps to strong taken. From the weak taken state, a not-taken outcome falls to strong not-taken.

For profiling, the block also compares the old guess at each update with the resolved outcome and counts the mismatches in a saturating counter. The block predicts direction only. It holds no target addresses and no global history.

Top module: `bp_dir_predictor`

## Requirements
- R1: After reset every slot holds state 00, so every lookup returns state 00 and a not-taken guess, and the misprediction count reads zero.
- R2: The lookup guess equals bit 1 of the slot state: states 00 and 01 guess not taken, and states 10 and 11 guess taken.
- R3: From state 00, a taken update moves the slot to 01 and a not-taken update leaves it at 00.
- R4: From state 01, a taken update moves the slot to 11 (skipping 10) and a not-taken update moves it to 00.
- R5: From state 10, a taken update moves the slot to 11 and a not-taken update moves it to 00 (skipping 01).
- R6: From state 11, a taken update leaves it at 11 and a not-taken update moves it to 10.
- R7: The slot index is (pc >> 2) modulo SLOTS, so the two low byte-offset bits are ignored. With 8 slots, 0x1C40 and 0x1C60 share slot 0 and 0x1C5C uses slot 7.
- R8: An update is a misprediction when bit 1 of the slot's state before the update differs from the outcome. upd_mispredict shows this in the same cycle, and miss_count rises by one on the following edge.
- R9: A lookup and an update of the same slot in the same cycle return the state from before that update. The new state is visible from the next cycle on.
- R10: miss_count saturates at its all-ones value and stays there on further mispredictions.
- R11: An update changes only the slot selected by its own index. All other slots keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Program counter of the branch being fetched |
| lk_taken | output | 1 | Direction guess for lk_pc (1 = taken) |
| lk_state | output | 2 | Current 2-bit state of the slot selected by lk_pc |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Program counter of the resolved branch |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |
| upd_mispredict | output | 1 | The old guess for upd_pc differs from upd_taken (valid while upd_valid) |
| miss_count | output | CNT_W | Saturating count of mispredicted updates |

## Verification
The hardest cases to reach are the two transitions that skip a state: 01 to 11, and 10 to 00. Each needs a slot that was steered into a weak state by an earlier update of the opposite outcome. The vector table therefore drives a single slot through a long scripted walk that passes every state under both outcomes. It presents each update on the same address as the lookup, so the pre-update state is observed in the very cycle it is replaced. Saturation of the counter needs a run of back-to-back mispredictions. The cycle 00→01→11→10→00 under taken, taken, not-taken, not-taken mispredicts on every step, so a narrowed counter reaches its limit within a few dozen cycles.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] bp_state_t;

  localparam bp_state_t ST_STRONG_NT = 2'b00;
  localparam bp_state_t ST_WEAK_NT   = 2'b01;
  localparam bp_state_t ST_WEAK_T    = 2'b10;
  localparam bp_state_t ST_STRONG_T  = 2'b11;

  // Direction guess carried by a state.
  function automatic logic bp_guess(input bp_state_t s);
    return s[1];
  endfunction

  // Non-saturating four-state transition.
  function automatic bp_state_t bp_next(input bp_state_t s, input logic taken);
    bp_state_t n;
    unique case (s)
      ST_STRONG_NT: n = taken ? ST_WEAK_NT  : ST_STRONG_NT;
      ST_WEAK_NT:   n = taken ? ST_STRONG_T : ST_STRONG_NT;
      ST_WEAK_T:    n = taken ? ST_STRONG_T : ST_STRONG_NT;
      default:      n = taken ? ST_STRONG_T : ST_WEAK_T;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W  = 32,
  parameter int SLOTS = 8,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);

  localparam logic [PC_W-1:0] SLOTS_W = PC_W'(SLOTS);

  // Word address reduced modulo the slot count.
  assign idx = IDX_W'((pc >> 2) % SLOTS_W);

endmodule

// File: rtl/bp_slot_table.sv
module bp_slot_table
  import bp_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output bp_state_t        rd_a_state,
  input  logic [IDX_W-1:0] rd_b_idx,
  output bp_state_t        rd_b_state,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  bp_state_t        wr_state,
  output logic [SLOTS-1:0] wr_sel
);

  bp_state_t slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign wr_sel[g] = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         slot_q[g] <= ST_STRONG_NT;
      else if (wr_sel[g]) slot_q[g] <= wr_state;
    end
  end

  // Reads see the registered state, so a same-cycle write is not visible.
  assign rd_a_state = slot_q[rd_a_idx];
  assign rd_b_state = slot_q[rd_b_idx];

endmodule

// File: rtl/bp_miss_counter.sv
module bp_miss_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count <= '0;
    else if (inc && (count != CNT_MAX)) count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/bp_dir_predictor.sv
module bp_dir_predictor
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int SLOTS = 8,
  parameter int CNT_W = 16,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_taken,
  output logic [1:0]       lk_state,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  output logic             upd_mispredict,
  output logic [CNT_W-1:0] miss_count
);

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] upd_idx;
  bp_state_t        lk_state_w;
  bp_state_t        upd_old_state;
  bp_state_t        upd_new_state;
  logic [SLOTS-1:0] slot_wr_sel;
  logic             miss_event;

  bp_index #(.PC_W(PC_W), .SLOTS(SLOTS)) u_lk_index (
    .pc  (lk_pc),
    .idx (lk_idx)
  );

  bp_index #(.PC_W(PC_W), .SLOTS(SLOTS)) u_upd_index (
    .pc  (upd_pc),
    .idx (upd_idx)
  );

  assign upd_new_state = bp_next(upd_old_state, upd_taken);

  bp_slot_table #(.SLOTS(SLOTS)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a_idx   (lk_idx),
    .rd_a_state (lk_state_w),
    .rd_b_idx   (upd_idx),
    .rd_b_state (upd_old_state),
    .wr_en      (upd_valid),
    .wr_idx     (upd_idx),
    .wr_state   (upd_new_state),
    .wr_sel     (slot_wr_sel)
  );

  assign lk_state       = lk_state_w;
  assign lk_taken       = bp_guess(lk_state_w);
  assign upd_mispredict = bp_guess(upd_old_state) != upd_taken;
  assign miss_event     = upd_valid && upd_mispredict;

  bp_miss_counter #(.CNT_W(CNT_W)) u_miss (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (miss_event),
    .count (miss_count)
  );

endmodule

// File: rtl/bp_dir_predictor_chk.sv
module bp_dir_predictor_chk #(
  parameter int SLOTS = 8,
  parameter int CNT_W = 16,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_valid,
  input logic             upd_taken,
  input logic             upd_mispredict,
  input logic [IDX_W-1:0] upd_idx,
  input logic [IDX_W-1:0] lk_idx,
  input logic [1:0]       lk_state,
  input logic [1:0]       upd_old_state,
  input logic [SLOTS-1:0] slot_wr_sel,
  input logic [CNT_W-1:0] miss_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> miss_count == '0); // R1

  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_mispredict && miss_count != CNT_MAX) |=>
      miss_count == $past(miss_count) + CNT_W'(1)); // R8

  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_mispredict) |=> $stable(miss_count)); // R8

  AST_MISS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count == CNT_MAX) |=> miss_count == CNT_MAX); // R10

  AST_OUTCOME_IN_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (lk_idx != $past(upd_idx)) || (lk_state[0] == $past(upd_taken))); // R3

  AST_TAKEN_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=>
      (lk_idx != $past(upd_idx)) || (lk_state >= $past(upd_old_state))); // R4

  AST_NOT_TAKEN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=>
      (lk_idx != $past(upd_idx)) || (lk_state <= $past(upd_old_state))); // R5

  AST_SINGLE_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_wr_sel)); // R11

endmodule

bind bp_dir_predictor bp_dir_predictor_chk #(
  .SLOTS(SLOTS), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .upd_valid      (upd_valid),
  .upd_taken      (upd_taken),
  .upd_mispredict (upd_mispredict),
  .upd_idx        (upd_idx),
  .lk_idx         (lk_idx),
  .lk_state       (lk_state),
  .upd_old_state  (upd_old_state),
  .slot_wr_sel    (slot_wr_sel),
  .miss_count     (miss_count)
);

// File: tb/bp_dir_predictor_tb.sv
module bp_dir_predictor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int NVEC       = 14;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [31:0]      lk_pc = '0;
  logic             lk_taken;
  logic [1:0]       lk_state;
  logic             upd_valid = 1'b0;
  logic [31:0]      upd_pc = '0;
  logic             upd_taken = 1'b0;
  logic             upd_mispredict;
  logic [CNT_W-1:0] miss_count;

  int n_vec = 0;
  int n_bad = 0;
  int exp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bp_dir_predictor #(.PC_W(32), .SLOTS(8), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_state(lk_state),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_mispredict(upd_mispredict), .miss_count(miss_count)
  );

  // Each entry: {pc, outcome, expected state before the update}, all on slot 0.
  localparam logic [34:0] VEC [NVEC] = '{
    {32'h40, 1'b1, 2'b00}, {32'h40, 1'b1, 2'b01}, {32'h40, 1'b1, 2'b11},
    {32'h40, 1'b0, 2'b11}, {32'h40, 1'b0, 2'b10}, {32'h40, 1'b0, 2'b00},
    {32'h40, 1'b1, 2'b00}, {32'h40, 1'b0, 2'b01}, {32'h40, 1'b1, 2'b00},
    {32'h40, 1'b1, 2'b01}, {32'h40, 1'b0, 2'b11}, {32'h40, 1'b1, 2'b10},
    {32'h40, 1'b0, 2'b11}, {32'h40, 1'b0, 2'b10}
  };

  function automatic string tag_of(input logic [1:0] s);
    case (s)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Same-address lookup and update in one cycle: old state must be visible (R9).
  task automatic step(input logic [31:0] pc, input logic t, input logic [1:0] old_s);
    logic mis;
    mis = (old_s[1] != t);
    @(negedge clk);
    lk_pc = pc; upd_pc = pc; upd_taken = t; upd_valid = 1'b1;
    #1;
    chk({tag_of(old_s), " R9 state before update"}, 32'(lk_state), 32'(old_s));
    chk("R2 guess", 32'(lk_taken), 32'(old_s[1]));
    chk("R8 mispredict flag", 32'(upd_mispredict), 32'(mis));
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    if (mis && exp_cnt < (1 << CNT_W) - 1) exp_cnt++;
    chk("R8 R10 miss count", 32'(miss_count), 32'(exp_cnt));
  endtask

  task automatic look(input logic [31:0] pc, input logic [1:0] exp_s, input string req);
    @(negedge clk);
    lk_pc = pc;
    #1;
    chk(req, 32'(lk_state), 32'(exp_s));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    upd_valid = 1'b0;
    exp_cnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: every slot starts at 00, count is zero
    for (int i = 0; i < 8; i++) begin
      look(32'(i * 4), 2'b00, "R1 reset state");
      chk("R1 reset guess", 32'(lk_taken), 32'd0);
    end
    chk("R1 reset count", 32'(miss_count), 32'd0);

    // Table walk over every state and outcome (R3..R6, R8, R9)
    for (int v = 0; v < NVEC; v++)
      step(VEC[v][34:3], VEC[v][2], VEC[v][1:0]);
    look(32'h40, 2'b00, "R5 final state after walk");

    // R10: all-mispredict loop on slot 1 drives the counter to its limit
    for (int k = 0; k < 3; k++) begin
      step(32'h44, 1'b1, 2'b00);
      step(32'h44, 1'b1, 2'b01);
      step(32'h44, 1'b0, 2'b11);
      step(32'h44, 1'b0, 2'b10);
    end
    chk("R10 saturated", 32'(miss_count), 32'((1 << CNT_W) - 1));

    // R11: slot 0 untouched by slot 1 traffic
    look(32'h40, 2'b00, "R11 other slot kept");

    // R1 again: reset mid-run clears state and count
    do_reset();
    #1;
    chk("R1 count after second reset", 32'(miss_count), 32'd0);
    look(32'h44, 2'b00, "R1 slot cleared");

    // R7: aliasing and ignored byte offset with 8 slots
    step(32'h1C40, 1'b1, 2'b00);
    look(32'h1C60, 2'b01, "R7 alias 0x1C60 shares slot 0");
    look(32'h1C42, 2'b01, "R7 byte offset ignored");
    look(32'h1C5C, 2'b00, "R7 R11 slot 7 untouched");
    step(32'h1C5C, 1'b1, 2'b00);
    look(32'h1C5C, 2'b01, "R7 slot 7 updated");
    look(32'h1C40, 2'b01, "R11 slot 0 kept");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule